// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 32 external interrupt lines and offers one request at a time to a processor core. Software reaches its state through word-wide registers. Enable bits and pending bits each have a pair of addresses: one address sets bits and the other clears them. Software can therefore change single bits without reading the register first. Each line has a 2-bit priority, where level 0 is the most urgent.

An asserted line is latched as pending. Among the lines that are both pending and enabled, the controller picks a winner. If the winner outranks everything currently in service, it is offered to the core.

The offer uses a valid/ready handshake. A transfer happens only on a clock edge where `irq_valid` and `irq_ready` are both high. Until that edge the offer reflects live state. The number may change, and valid may drop, while the core holds ready low, for example when a more urgent line becomes pending or the winner is disabled. On a transfer the interrupt moves from pending to active. A pulse on `exc_ret` ends service of the most urgent active interrupt, which lowers the execution level again. Register reads are combinational, and register writes take effect at the clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A write to offset 0x100 sets each enable bit whose data bit is 1 and leaves the others unchanged. Byte enable `bus_be[k]` gates data bits 8k+7..8k. Reads at both 0x100 and 0x180 return the enable vector.
- R2: A write to offset 0x180 clears each enable bit whose data bit is 1, with the same byte gating, and leaves zero bits without effect.
- R3: A write to offset 0x200 sets pending bits and a write to 0x280 clears them, both with 1-bits only. Reads at both offsets return the pending vector.
- R4: A high line sets its pending bit even when the line is disabled. A disabled interrupt is never offered, whatever its priority.
- R5: The priority word at offset 0x400+4n holds interrupts 4n..4n+3. Interrupt 4n+k uses bits 8k+7..8k+6. All other bits read as 0, and unmapped offsets read as 0.
- R6: A priority-word write whose `bus_be` is not 4'hF is ignored.
- R7: The offered interrupt has the lowest priority value among pending and enabled interrupts. On a tie in value, the lowest number wins.
- R8: An interrupt is offered only if its priority value is strictly below the execution level. The execution level is the lowest value among active interrupts, or 4 when none is active. On a handshake edge the interrupt's pending bit clears and its active bit (`active_vec`) sets.
- R9: A clear-pending write leaves the active state unchanged.
- R10: An `exc_ret` pulse clears the active bit of the most urgent active interrupt, with ties broken toward the lowest number. A line does not re-pend while its interrupt is active. A line still high after its active state ends becomes pending on the following clock edge.
- R11: After reset, all enable, pending, priority and active state is zero, and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_line | input | 32 | Interrupt lines, active high |
| irq_valid | output | 1 | An interrupt is offered to the core |
| irq_ready | input | 1 | Core accepts the offered interrupt |
| irq_num | output | 5 | Number of the offered interrupt |
| exc_ret | input | 1 | Exception return: end the most urgent active interrupt |
| active_vec | output | 32 | Interrupts currently in service |

## Verification
The hardest states to reach are nested ones. One example is an urgent interrupt preempting a less urgent one that is still active. Another is a same-level pending interrupt that must wait until the level below it returns. A third is a line held high across its own service, which must re-pend only after the return. The stimulus reaches these states by writing chosen priorities and then forcing the pending order through set-pending writes. Each handshake is a single ready pulse, with the accepted number predicted in the bench's queue. Between returns, the bench samples `irq_valid`, `active_vec` and the pending readback to confirm blocking and re-pending.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned BUS_AW = 12;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_SETEN  = 12'h100;
  localparam logic [BUS_AW-1:0] OFS_CLREN  = 12'h180;
  localparam logic [BUS_AW-1:0] OFS_SETPND = 12'h200;
  localparam logic [BUS_AW-1:0] OFS_CLRPND = 12'h280;
  localparam logic [BUS_AW-1:0] OFS_PRIO   = 12'h400;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SETEN,
    SEL_CLREN,
    SEL_SETPND,
    SEL_CLRPND,
    SEL_PRIO
  } reg_sel_e;

  function automatic logic [BUS_DW-1:0] lane_mask(input logic [BUS_DW/8-1:0] be);
    logic [BUS_DW-1:0] m;
    for (int k = 0; k < BUS_DW/8; k++) m[k*8 +: 8] = {8{be[k]}};
    return m;
  endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import prio_irq_pkg::*;
#(
  parameter int N_IRQ  = 32,
  parameter int PRIO_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [BUS_AW-1:0]       bus_addr,
  input  logic [BUS_DW-1:0]       bus_wdata,
  input  logic [BUS_DW/8-1:0]     bus_be,
  output logic [BUS_DW-1:0]       bus_rdata,
  input  logic [N_IRQ-1:0]        irq_line,
  input  logic [N_IRQ-1:0]        active_q,
  input  logic [N_IRQ-1:0]        take_vec,
  output logic [N_IRQ-1:0]        en_q,
  output logic [N_IRQ-1:0]        pend_q,
  output logic [N_IRQ*PRIO_W-1:0] prio_q
);
  localparam int LANES  = BUS_DW / 8;
  localparam int N_PREG = (N_IRQ + LANES - 1) / LANES;

  reg_sel_e          sel;
  logic [2:0]        pidx;
  logic              wr;
  logic              prio_wr;
  logic [BUS_DW-1:0] wmask;
  logic [N_IRQ-1:0]  set_en, clr_en, set_pnd, clr_pnd;

  // Address decode: word aligned offsets only
  always_comb begin
    pidx = bus_addr[4:2];
    sel  = SEL_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr == OFS_SETEN)       sel = SEL_SETEN;
      else if (bus_addr == OFS_CLREN)  sel = SEL_CLREN;
      else if (bus_addr == OFS_SETPND) sel = SEL_SETPND;
      else if (bus_addr == OFS_CLRPND) sel = SEL_CLRPND;
      else if (bus_addr[BUS_AW-1:5] == OFS_PRIO[BUS_AW-1:5] && int'(pidx) < N_PREG)
        sel = SEL_PRIO;
    end
  end

  assign wr      = bus_en && bus_we;
  assign wmask   = bus_wdata & lane_mask(bus_be);
  assign prio_wr = wr && (sel == SEL_PRIO) && (bus_be == '1);

  assign set_en  = (wr && sel == SEL_SETEN)  ? wmask[N_IRQ-1:0] : '0;
  assign clr_en  = (wr && sel == SEL_CLREN)  ? wmask[N_IRQ-1:0] : '0;
  assign set_pnd = (wr && sel == SEL_SETPND) ? wmask[N_IRQ-1:0] : '0;
  assign clr_pnd = (wr && sel == SEL_CLRPND) ? wmask[N_IRQ-1:0] : '0;

  // Enable and pending state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= (en_q & ~clr_en) | set_en;
      // lines re-pend only while not in service; an accepted bit always clears
      pend_q <= ((pend_q & ~clr_pnd) | set_pnd | (irq_line & ~active_q)) & ~take_vec;
    end
  end

  // Priority fields: top PRIO_W bits of each byte lane
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (prio_wr) begin
      for (int g = 0; g < N_IRQ; g++) begin
        if (pidx == 3'(g / LANES))
          prio_q[g*PRIO_W +: PRIO_W] <= bus_wdata[(g % LANES)*8 + 7 -: PRIO_W];
      end
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      unique case (sel)
        SEL_SETEN, SEL_CLREN:   bus_rdata[N_IRQ-1:0] = en_q;
        SEL_SETPND, SEL_CLRPND: bus_rdata[N_IRQ-1:0] = pend_q;
        SEL_PRIO: begin
          for (int k = 0; k < LANES; k++) begin
            if (int'(pidx) * LANES + k < N_IRQ)
              bus_rdata[k*8 + 7 -: PRIO_W] = prio_q[(int'(pidx) * LANES + k)*PRIO_W +: PRIO_W];
          end
        end
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int N      = 32,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]        req,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                found,
  output logic [IDX_W-1:0]    win_idx,
  output logic [PRIO_W-1:0]   win_prio
);
  localparam int NLVL = 1 << PRIO_W;

  logic [NLVL*N-1:0] lvl_hit;

  // One request mask per priority level
  for (genvar L = 0; L < NLVL; L++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign lvl_hit[L*N + i] = req[i] && (prio[i*PRIO_W +: PRIO_W] == PRIO_W'(L));
    end
  end

  // Lowest populated level wins; inside it the lowest index wins.
  // Scanning downward lets the last hit overwrite earlier ones.
  always_comb begin
    logic [N-1:0] sl;
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int L = NLVL - 1; L >= 0; L--) begin
      sl = lvl_hit[L*N +: N];
      if (|sl) begin
        found    = 1'b1;
        win_prio = PRIO_W'(L);
        for (int i = N - 1; i >= 0; i--) begin
          if (sl[i]) win_idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/pic_active.sv
module pic_active #(
  parameter int N_IRQ = 32,
  parameter int IDX_W = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] take_vec,
  input  logic             exc_ret,
  input  logic             ret_found,
  input  logic [IDX_W-1:0] ret_idx,
  output logic [N_IRQ-1:0] active_q
);
  logic [N_IRQ-1:0] ret_vec;

  always_comb begin
    ret_vec = '0;
    if (exc_ret && ret_found) ret_vec[ret_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= (active_q & ~ret_vec) | take_vec;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_IRQ  = 32,
  parameter int PRIO_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_en,
  input  logic                       bus_we,
  input  logic [11:0]                bus_addr,
  input  logic [31:0]                bus_wdata,
  input  logic [3:0]                 bus_be,
  output logic [31:0]                bus_rdata,
  input  logic [N_IRQ-1:0]           irq_line,
  output logic                       irq_valid,
  input  logic                       irq_ready,
  output logic [$clog2(N_IRQ)-1:0]   irq_num,
  input  logic                       exc_ret,
  output logic [N_IRQ-1:0]           active_vec
);
  localparam int IDX_W = $clog2(N_IRQ);
  localparam int LVL_W = PRIO_W + 1;

  logic [N_IRQ-1:0]        en_q, pend_q, take_vec;
  logic [N_IRQ*PRIO_W-1:0] prio_q;
  logic                    cand_found, act_found;
  logic [IDX_W-1:0]        cand_idx, act_idx;
  logic [PRIO_W-1:0]       cand_prio, act_prio;
  logic [LVL_W-1:0]        exec_lvl;
  logic                    take;

  pic_regs #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .irq_line(irq_line), .active_q(active_vec), .take_vec(take_vec),
    .en_q(en_q), .pend_q(pend_q), .prio_q(prio_q)
  );

  // Winner among pending and enabled lines
  pic_arbiter #(.N(N_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb_pend (
    .req(pend_q & en_q), .prio(prio_q),
    .found(cand_found), .win_idx(cand_idx), .win_prio(cand_prio)
  );

  // Most urgent active interrupt: sets execution level and return target
  pic_arbiter #(.N(N_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb_act (
    .req(active_vec), .prio(prio_q),
    .found(act_found), .win_idx(act_idx), .win_prio(act_prio)
  );

  assign exec_lvl  = act_found ? {1'b0, act_prio} : LVL_W'(1 << PRIO_W);
  assign irq_valid = cand_found && ({1'b0, cand_prio} < exec_lvl);
  assign irq_num   = cand_idx;
  assign take      = irq_valid && irq_ready;

  always_comb begin
    take_vec = '0;
    if (take) take_vec[cand_idx] = 1'b1;
  end

  pic_active #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_active (
    .clk(clk), .rst_n(rst_n), .take_vec(take_vec),
    .exc_ret(exc_ret), .ret_found(act_found), .ret_idx(act_idx),
    .active_q(active_vec)
  );
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N_IRQ  = 32,
  parameter int PRIO_W = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       irq_valid,
  input logic                       irq_ready,
  input logic [$clog2(N_IRQ)-1:0]   irq_num,
  input logic                       exc_ret,
  input logic [N_IRQ-1:0]           active_vec,
  input logic [N_IRQ-1:0]           pend_vec,
  input logic [N_IRQ-1:0]           en_vec,
  input logic [N_IRQ*PRIO_W-1:0]    prio_vec,
  input logic [PRIO_W:0]            exec_lvl
);
  // R4: only pending and enabled interrupts are offered
  a_r4_offer_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (en_vec[irq_num] && pend_vec[irq_num]));

  // R8: offer must strictly beat the execution level
  a_r8_strict_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ({1'b0, prio_vec[irq_num*PRIO_W +: PRIO_W]} < exec_lvl));

  // R8: handshake moves the interrupt from pending to active
  a_r8_take_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> (active_vec[$past(irq_num)] && !pend_vec[$past(irq_num)]));

  // R9: active state changes only on handshake or return
  a_r9_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(irq_valid && irq_ready) && !exc_ret) |=> $stable(active_vec));

  // R10: a return ends exactly one active interrupt
  a_r10_ret_one: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret && (active_vec != '0) && !(irq_valid && irq_ready))
      |=> ($countones(active_vec) + 1 == $countones($past(active_vec))));
endmodule

bind prio_irq_ctrl pic_chk #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_num(irq_num), .exc_ret(exc_ret), .active_vec(active_vec),
  .pend_vec(pend_q), .en_vec(en_q), .prio_vec(prio_q), .exec_lvl(exec_lvl)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_rdata;
  logic [31:0] irq_line = '0;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [4:0]  irq_num;
  logic        exc_ret = 1'b0;
  logic [31:0] active_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .irq_line(irq_line), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_num(irq_num), .exc_ret(exc_ret),
    .active_vec(active_vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    bus_en = 1'b0;
  endtask

  // driver: predict the accepted number, then pulse ready for one cycle
  task automatic take(input int n);
    exp_q.push_back(n);
    irq_ready = 1'b1;
    @(posedge clk); #1;
    irq_ready = 1'b0;
  endtask

  task automatic ret();
    exc_ret = 1'b1;
    @(posedge clk); #1;
    exc_ret = 1'b0;
  endtask

  // monitor: compare each handshake against the scoreboard
  always @(negedge clk) begin
    if (rst_n && irq_valid && irq_ready) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected handshake", 32'(irq_num), 32'hFFFF_FFFF);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk("R7/R8 accepted number", 32'(irq_num), 32'(e));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R11: reset state
    rd(12'h100, 32'h0, "R11 enable reset");
    rd(12'h200, 32'h0, "R11 pending reset");
    rd(12'h400, 32'h0, "R11 priority reset");
    rd(12'h300, 32'h0, "R5 unmapped read");
    chk("R11 no request", {31'd0, irq_valid}, 32'h0);
    chk("R11 active reset", active_vec, 32'h0);

    // R1 / R2: enable set and clear
    wr(12'h100, 32'h0000_00F0);
    rd(12'h100, 32'h0000_00F0, "R1 set-enable read");
    rd(12'h180, 32'h0000_00F0, "R1 clear-enable read");
    wr(12'h100, 32'h0000_0003);
    rd(12'h100, 32'h0000_00F3, "R1 zeros keep bits");
    wr(12'h100, 32'hFFFF_FFFF, 4'b0010);
    rd(12'h100, 32'h0000_FFF3, "R1 byte gating");
    wr(12'h180, 32'h0000_0F00);
    rd(12'h180, 32'h0000_F0F3, "R2 clear-enable");
    wr(12'h180, 32'hFFFF_FFFF);
    rd(12'h100, 32'h0, "R2 clear all");

    // R3: pending set and clear
    wr(12'h200, 32'h8000_0001);
    rd(12'h200, 32'h8000_0001, "R3 set-pending read");
    rd(12'h280, 32'h8000_0001, "R3 clear-pending read");
    wr(12'h280, 32'h0000_0001);
    rd(12'h200, 32'h8000_0000, "R3 clear one");
    wr(12'h280, 32'h8000_0000);
    rd(12'h280, 32'h0, "R3 clear last");

    // R5 / R6: priority words
    wr(12'h404, 32'hFFFF_FFFF);
    rd(12'h404, 32'hC0C0_C0C0, "R5 only top bits kept");
    wr(12'h404, 32'h4080_00C0);
    rd(12'h404, 32'h4080_00C0, "R5 per-lane fields");
    wr(12'h404, 32'h0, 4'b0001);
    rd(12'h404, 32'h4080_00C0, "R6 partial write ignored");
    wr(12'h41C, 32'h00C0_0000);
    rd(12'h41C, 32'h00C0_0000, "R5 last priority word");
    wr(12'h41C, 32'h0);
    wr(12'h404, 32'h0);

    // R4: line pends while disabled, never offered
    irq_line[3] = 1'b1;
    cyc(1);
    irq_line[3] = 1'b0;
    rd(12'h200, 32'h0000_0008, "R4 disabled line pends");
    cyc(3);
    chk("R4 disabled not offered", {31'd0, irq_valid}, 32'h0);
    wr(12'h100, 32'h0000_0008);
    chk("R4 offered once enabled", {31'd0, irq_valid}, 32'h1);
    take(3);
    chk("R8 active after take", active_vec, 32'h0000_0008);
    rd(12'h200, 32'h0, "R8 pending cleared by take");
    ret();
    chk("R10 return clears", active_vec, 32'h0);

    // R7: level then number ordering
    wr(12'h400, 32'h4040_80C0);
    wr(12'h100, 32'h0000_000F);
    wr(12'h200, 32'h0000_000F);
    chk("R7 lowest value lowest number", 32'(irq_num), 32'd2);
    take(2);
    chk("R8 equal level blocked", {31'd0, irq_valid}, 32'h0);
    ret();
    take(3);
    ret();
    take(1);
    ret();
    take(0);
    ret();
    rd(12'h200, 32'h0, "R7 all served");

    // R8 / R10: preemption and strict comparison
    wr(12'h404, 32'h0080_8000);
    wr(12'h100, 32'h0000_0070);
    wr(12'h200, 32'h0000_0020);
    take(5);
    wr(12'h200, 32'h0000_0010);
    chk("R8 urgent preempts", 32'(irq_num), 32'd4);
    take(4);
    chk("R8 nested active", active_vec, 32'h0000_0030);
    wr(12'h200, 32'h0000_0040);
    chk("R8 blocked under level 0", {31'd0, irq_valid}, 32'h0);
    ret();
    chk("R10 most urgent returns first", active_vec, 32'h0000_0020);
    chk("R8 same level not offered", {31'd0, irq_valid}, 32'h0);
    ret();
    chk("R8 offered after return", {31'd0, irq_valid}, 32'h1);
    take(6);

    // R9: clear-pending leaves active alone
    wr(12'h200, 32'h0000_0040);
    rd(12'h200, 32'h0000_0040, "R9 pend while active");
    wr(12'h280, 32'h0000_0040);
    rd(12'h200, 32'h0, "R9 pending cleared");
    chk("R9 active kept", active_vec, 32'h0000_0040);
    ret();

    // R10: held line re-pends only after return
    wr(12'h100, 32'h0000_0200);
    irq_line[9] = 1'b1;
    cyc(1);
    take(9);
    cyc(2);
    rd(12'h200, 32'h0, "R10 no re-pend while active");
    chk("R10 active held line", active_vec, 32'h0000_0200);
    ret();
    rd(12'h200, 32'h0, "R10 return edge no pend yet");
    cyc(1);
    rd(12'h200, 32'h0000_0200, "R10 re-pend after return");
    irq_line[9] = 1'b0;
    take(9);
    ret();
    rd(12'h200, 32'h0, "R10 final pending");
    chk("R10 final active", active_vec, 32'h0);

    cyc(2);
    chk("scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule